// File: doc/BRIEF.md
# Dual-Plane Regenerating Word Store Controller

This controller fronts a word store built from two bit planes whose cells must be rewritten at regular intervals to keep their contents. Time is divided into minor cycles of `MINOR_CLKS` clocks. Each minor cycle carries exactly one operation: a processor read, a processor write, or one background regeneration step. A regeneration counter walks through every location in turn. A full pass over the store is a major cycle.

A static mode input selects how the two planes are used. In mirrored mode (`mode_ext` = 0) the store holds 1024 words, and every word lives in both planes. On a read or a regeneration step, a bit counts as one when either plane returns one, and that resolved value is written back to both planes. A one therefore survives a stuck-at-zero cell in either plane. In split mode (`mode_ext` = 1) the store holds 2048 words. Address bit 10 picks the plane, so the first half of the major cycle refreshes plane 0 and the second half refreshes plane 1. Each plane models a stuck-at-zero defect mask for each word, written through a fault-injection port. A cell under a defect bit stores and returns zero. Mode may change only while reset is held. Reset clears the defect masks but leaves the stored words in place.

The states are held in `slot_e`. `SL_REGEN` refreshes the location named by the regeneration counter. `SL_READ` serves a captured read. `SL_WRITE` serves a captured write. At the last clock of every slot the controller moves on. If a request is pending, or is captured on that same clock, it goes to `SL_WRITE` or `SL_READ` (a write when the write strobe was set). Otherwise it goes to `SL_REGEN`. Reset enters `SL_REGEN` at slot position 0.

Top module: `dmem_ctrl`

## Requirements
- R1: After reset, `cpu_busy`, `cpu_done` and `rg_step` are 0 and `rg_addr` is 0.
- R2: Every slot lasts exactly `MINOR_CLKS` clocks and produces exactly one one-clock event: `rg_step` for a regeneration step, or `cpu_done` for an access. Consecutive events are therefore `MINOR_CLKS` clocks apart.
- R3: The regeneration addresses reported on `rg_addr` with `rg_step` start at 0 after reset and step by one. In mirrored mode, bit 10 is always 0 and the address wraps from 1023 to 0. In split mode it goes from 1023 to 1024 and wraps from 2047 to 0.
- R4: A strobe is taken only while `cpu_busy` is 0. `cpu_busy` rises on the clock after the strobe, stays high until the access completes, and is 0 in the cycle `cpu_done` is high. Strobes that arrive while busy have no effect on the store.
- R5: `cpu_done` is a one-clock pulse. For a read, `cpu_rdata` holds the resolved word in that cycle. `cpu_done` appears between `MINOR_CLKS`+1 and 2*`MINOR_CLKS` clocks after the strobe clock.
- R6: In mirrored mode, writes go to both planes. A read returns the bitwise OR of the two planes, so a word written while one plane has stuck-at-zero bits reads back intact. The resolved value is rewritten to both planes, so after the defect is cleared the healed plane holds the full word again.
- R7: In split mode, `cpu_addr[10]` = 0 selects plane 0 and 1 selects plane 1, at location `cpu_addr[9:0]`. Stuck-at-zero bits of the selected plane read back as 0.
- R8: In mirrored mode, `cpu_addr[10]` is ignored: addresses a and a+1024 name the same word.
- R9: An access delays regeneration but skips no location. The next `rg_step` after an access reports the address following the last one reported.
- R10: When `cpu_rd` and `cpu_wr` are both set on the same clock, the request is served as a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_ext | input | 1 | 0: mirrored 1024-word mode, 1: split 2048-word mode; static outside reset |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_done` after a read |
| cpu_busy | output | 1 | Request held or in service |
| cpu_done | output | 1 | Access completed (one clock) |
| rg_step | output | 1 | A regeneration step completed (one clock) |
| rg_addr | output | ADDR_W | Address refreshed by the last regeneration step |
| flt_we | input | 1 | Load a defect mask |
| flt_plane | input | 1 | Plane receiving the mask |
| flt_loc | input | ADDR_W-1 | Location receiving the mask |
| flt_mask | input | DATA_W | Stuck-at-zero bits (1 = stuck) |

## Verification
The assertions rely on `mode_ext` changing only while `rst_n` is low. They also rely on the strobes being single-clock pulses, so that the spacing and sequence checks see one request at a time. The bench changes mode only inside its reset task. It raises `cpu_rd` and `cpu_wr` for one clock. It waits for `cpu_busy` to clear before each regular request and sends a strobe into a busy slot only on purpose. Defect masks are loaded through their port between accesses. Every corner is reached through the ports: the OR healing, the rewrite after a defect is cleared, split-plane selection, and the counter wraps in both modes.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

    typedef enum logic [1:0] {
        SL_REGEN = 2'd0,
        SL_READ  = 2'd1,
        SL_WRITE = 2'd2
    } slot_e;

    function automatic logic [10:0] rg_advance(input logic [10:0] cur, input logic ext);
        logic [10:0] inc;
        inc = cur + 11'd1;
        return ext ? inc : {1'b0, inc[9:0]};
    endfunction

endpackage

// File: rtl/dmem_plane.sv
module dmem_plane #(
    parameter int LOC_W  = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LOC_W-1:0]  rd_loc,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [LOC_W-1:0]  wr_loc,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              flt_we,
    input  logic [LOC_W-1:0]  flt_loc,
    input  logic [DATA_W-1:0] flt_mask
);
    localparam int DEPTH = 1 << LOC_W;

    logic [DATA_W-1:0] cell_q   [DEPTH];
    logic [DATA_W-1:0] defect_q [DEPTH];

    // stored cells: a stuck bit never takes a one
    always_ff @(posedge clk) begin
        if (wr_en) begin
            cell_q[wr_loc] <= wr_data & ~defect_q[wr_loc];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                defect_q[i] <= '0;
            end
        end else if (flt_we) begin
            defect_q[flt_loc] <= flt_mask;
        end
    end

    assign rd_data = cell_q[rd_loc] & ~defect_q[rd_loc];

endmodule

// File: rtl/dmem_seq.sv
module dmem_seq
    import dmem_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int DATA_W     = 16,
    parameter int MINOR_CLKS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_ext,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              op_regen,
    output logic              op_read,
    output logic              op_write,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_wdata,
    output logic              cpu_busy,
    output logic              cpu_done,
    output logic              rg_step,
    output logic [ADDR_W-1:0] rg_addr
);
    localparam int CNT_W = (MINOR_CLKS > 1) ? $clog2(MINOR_CLKS) : 1;
    localparam logic [CNT_W-1:0] SLOT_LAST = CNT_W'(MINOR_CLKS - 1);

    slot_e             state_q, state_d;
    logic [CNT_W-1:0]  slot_q;
    logic              busy_q, pend_q, pwr_q, done_q, step_q;
    logic [ADDR_W-1:0] paddr_q, rg_q, rgaddr_q;
    logic [DATA_W-1:0] pdata_q;
    logic              slot_end, capture;
    logic [ADDR_W-1:0] cap_addr;

    assign slot_end = (slot_q == SLOT_LAST);
    assign capture  = !busy_q && (cpu_rd || cpu_wr);
    assign cap_addr = mode_ext ? cpu_addr : {1'b0, cpu_addr[ADDR_W-2:0]};

    // next slot choice
    always_comb begin
        state_d = state_q;
        if (slot_end) begin
            if (pend_q) begin
                state_d = pwr_q ? SL_WRITE : SL_READ;
            end else if (capture) begin
                state_d = cpu_wr ? SL_WRITE : SL_READ;
            end else begin
                state_d = SL_REGEN;
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SL_REGEN;
            slot_q  <= '0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_end ? '0 : slot_q + CNT_W'(1);
        end
    end

    // outputs and request holding
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            pend_q   <= 1'b0;
            pwr_q    <= 1'b0;
            paddr_q  <= '0;
            pdata_q  <= '0;
            rg_q     <= '0;
            rgaddr_q <= '0;
            done_q   <= 1'b0;
            step_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            step_q <= 1'b0;
            if (capture) begin
                busy_q  <= 1'b1;
                pend_q  <= !slot_end;
                pwr_q   <= cpu_wr;
                paddr_q <= cap_addr;
                pdata_q <= cpu_wdata;
            end else if (slot_end && pend_q) begin
                pend_q <= 1'b0;
            end
            if (slot_end) begin
                unique case (state_q)
                    SL_REGEN: begin
                        step_q   <= 1'b1;
                        rgaddr_q <= rg_q;
                        rg_q     <= rg_advance(rg_q, mode_ext);
                    end
                    SL_READ, SL_WRITE: begin
                        done_q <= 1'b1;
                        busy_q <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign op_regen = slot_end && (state_q == SL_REGEN);
    assign op_read  = slot_end && (state_q == SL_READ);
    assign op_write = slot_end && (state_q == SL_WRITE);
    assign op_addr  = (state_q == SL_REGEN) ? rg_q : paddr_q;
    assign op_wdata = pdata_q;
    assign cpu_busy = busy_q;
    assign cpu_done = done_q;
    assign rg_step  = step_q;
    assign rg_addr  = rgaddr_q;

endmodule

// File: rtl/dmem_ctrl.sv
module dmem_ctrl
    import dmem_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int DATA_W     = 16,
    parameter int MINOR_CLKS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_ext,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_busy,
    output logic              cpu_done,
    output logic              rg_step,
    output logic [ADDR_W-1:0] rg_addr,
    input  logic              flt_we,
    input  logic              flt_plane,
    input  logic [ADDR_W-2:0] flt_loc,
    input  logic [DATA_W-1:0] flt_mask
);
    localparam int LOC_W   = ADDR_W - 1;
    localparam int PLANES  = 2;

    logic              op_regen, op_read, op_write, op_fire;
    logic [ADDR_W-1:0] op_addr;
    logic [DATA_W-1:0] op_wdata, resolved, wr_word;
    logic [DATA_W-1:0] plane_rd [PLANES];
    logic [PLANES-1:0] plane_we;
    logic              hi_sel;
    logic [DATA_W-1:0] rdata_q;

    dmem_seq #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .MINOR_CLKS(MINOR_CLKS)
    ) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_ext (mode_ext),
        .cpu_rd   (cpu_rd),
        .cpu_wr   (cpu_wr),
        .cpu_addr (cpu_addr),
        .cpu_wdata(cpu_wdata),
        .op_regen (op_regen),
        .op_read  (op_read),
        .op_write (op_write),
        .op_addr  (op_addr),
        .op_wdata (op_wdata),
        .cpu_busy (cpu_busy),
        .cpu_done (cpu_done),
        .rg_step  (rg_step),
        .rg_addr  (rg_addr)
    );

    assign op_fire = op_regen || op_read || op_write;
    assign hi_sel  = op_addr[ADDR_W-1];

    // mirrored: OR of planes; split: the addressed plane
    assign resolved = mode_ext ? (hi_sel ? plane_rd[1] : plane_rd[0])
                               : (plane_rd[0] | plane_rd[1]);
    assign wr_word  = op_write ? op_wdata : resolved;

    for (genvar g = 0; g < PLANES; g++) begin : g_plane
        assign plane_we[g] = op_fire && (!mode_ext || (hi_sel == (g != 0)));

        dmem_plane #(
            .LOC_W (LOC_W),
            .DATA_W(DATA_W)
        ) plane_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .rd_loc  (op_addr[LOC_W-1:0]),
            .rd_data (plane_rd[g]),
            .wr_en   (plane_we[g]),
            .wr_loc  (op_addr[LOC_W-1:0]),
            .wr_data (wr_word),
            .flt_we  (flt_we && (flt_plane == (g != 0))),
            .flt_loc (flt_loc),
            .flt_mask(flt_mask)
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (op_read) begin
            rdata_q <= resolved;
        end
    end

    assign cpu_rdata = rdata_q;

endmodule

// File: rtl/dmem_ctrl_chk.sv
module dmem_ctrl_chk #(
    parameter int ADDR_W     = 11,
    parameter int MINOR_CLKS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_ext,
    input logic              cpu_busy,
    input logic              cpu_done,
    input logic              rg_step,
    input logic [ADDR_W-1:0] rg_addr
);
    localparam int GAP_W = $clog2(MINOR_CLKS + 2) + 1;

    logic [GAP_W-1:0]  gap_q;
    logic              ev_seen_q, rg_seen_q;
    logic [ADDR_W-1:0] rg_last_q, rg_next;
    logic [ADDR_W-1:0] rg_inc;

    assign rg_inc  = rg_last_q + ADDR_W'(1);
    assign rg_next = mode_ext ? rg_inc : {1'b0, rg_inc[ADDR_W-2:0]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q     <= '0;
            ev_seen_q <= 1'b0;
            rg_seen_q <= 1'b0;
            rg_last_q <= '0;
        end else begin
            if (rg_step || cpu_done) begin
                gap_q     <= '0;
                ev_seen_q <= 1'b1;
            end else if (gap_q != '1) begin
                gap_q <= gap_q + GAP_W'(1);
            end
            if (rg_step) begin
                rg_seen_q <= 1'b1;
                rg_last_q <= rg_addr;
            end
        end
    end

    AST_SLOT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_seen_q && (rg_step || cpu_done)) |-> (gap_q == GAP_W'(MINOR_CLKS - 1))); // R2

    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        !(rg_step && cpu_done)); // R2

    AST_RG_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (rg_seen_q && rg_step) |-> (rg_addr == rg_next)); // R9

    AST_RG_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_ext && rg_step) |-> !rg_addr[ADDR_W-1]); // R3

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done); // R5

    AST_DONE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |-> !cpu_busy); // R4

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_busy |=> (cpu_busy || cpu_done)); // R4

endmodule

bind dmem_ctrl dmem_ctrl_chk #(
    .ADDR_W    (ADDR_W),
    .MINOR_CLKS(MINOR_CLKS)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_ext(mode_ext),
    .cpu_busy(cpu_busy),
    .cpu_done(cpu_done),
    .rg_step (rg_step),
    .rg_addr (rg_addr)
);

// File: tb/dmem_ctrl_tb_top.sv
module dmem_ctrl_tb_top;
    localparam int AW = 11;
    localparam int DW = 16;
    localparam int M  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_ext = 1'b0;
    logic          cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic [DW-1:0] cpu_rdata;
    logic          cpu_busy, cpu_done, rg_step;
    logic [AW-1:0] rg_addr;
    logic          flt_we = 1'b0, flt_plane = 1'b0;
    logic [AW-2:0] flt_loc = '0;
    logic [DW-1:0] flt_mask = '0;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    dmem_ctrl #(.ADDR_W(AW), .DATA_W(DW), .MINOR_CLKS(M)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_ext(mode_ext),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_busy(cpu_busy), .cpu_done(cpu_done),
        .rg_step(rg_step), .rg_addr(rg_addr),
        .flt_we(flt_we), .flt_plane(flt_plane), .flt_loc(flt_loc),
        .flt_mask(flt_mask)
    );

    typedef struct {
        bit          is_rd;
        logic [DW-1:0] exp;
        string       req;
    } sb_item_t;

    sb_item_t sb_q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // monitor: scoreboard on completions
    always @(negedge clk) begin
        if (rst_n && cpu_done) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R5", "unexpected done", 1, 0);
            end else begin
                sb_item_t it;
                it = sb_q.pop_front();
                if (it.is_rd)
                    chk(cpu_rdata == it.exp, it.req, "read data", cpu_rdata, it.exp);
            end
        end
    end

    // monitor: slot spacing and regeneration order
    int          gap = 0;
    bit          ev_seen = 0, rg_seen = 0;
    logic [AW-1:0] rg_last = '0;
    bit          wrap_mir = 0, cross_ext = 0, wrap_ext = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            gap = 0; ev_seen = 0; rg_seen = 0;
        end else begin
            gap++;
            if (rg_step || cpu_done) begin
                if (ev_seen) chk(gap == M, "R2", "slot spacing", gap, M);
                gap = 0;
                ev_seen = 1;
            end
            if (rg_step) begin
                logic [AW-1:0] want;
                if (!rg_seen) want = '0;
                else if (mode_ext) want = rg_last + 1'b1;
                else want = {1'b0, 10'(rg_last[9:0] + 10'd1)};
                chk(rg_addr == want, rg_seen ? "R9" : "R3", "regen address", rg_addr, want);
                if (rg_seen && !mode_ext && rg_last == 11'd1023 && rg_addr == 11'd0) wrap_mir = 1;
                if (rg_seen && mode_ext && rg_last == 11'd1023 && rg_addr == 11'd1024) cross_ext = 1;
                if (rg_seen && mode_ext && rg_last == 11'd2047 && rg_addr == 11'd0) wrap_ext = 1;
                rg_last = rg_addr;
                rg_seen = 1;
            end
        end
    end

    task automatic do_reset(input logic ext);
        @(negedge clk);
        rst_n = 1'b0;
        mode_ext = ext;
        repeat (3) @(negedge clk);
        chk(cpu_busy == 0 && cpu_done == 0 && rg_step == 0 && rg_addr == 0,
            "R1", "reset outputs", {cpu_busy, cpu_done, rg_step, rg_addr}, 0);
        rst_n = 1'b1;
    endtask

    task automatic access(input bit wr, input bit rd, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, input logic [DW-1:0] exp,
                          input string req);
        sb_item_t it;
        int lat;
        while (cpu_busy) @(negedge clk);
        it.is_rd = !wr;
        it.exp = exp;
        it.req = req;
        sb_q.push_back(it);
        cpu_wr = wr; cpu_rd = rd; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 0; cpu_rd = 0;
        chk(cpu_busy == 1, "R4", "busy after strobe", cpu_busy, 1);
        lat = 1;
        while (!cpu_done) begin
            @(negedge clk);
            lat++;
        end
        chk(lat >= M + 1 && lat <= 2 * M, "R5", "done latency", lat, M + 1);
        chk(cpu_busy == 0, "R4", "busy clear with done", cpu_busy, 0);
    endtask

    task automatic inject(input bit p, input logic [AW-2:0] loc, input logic [DW-1:0] m);
        @(negedge clk);
        flt_we = 1; flt_plane = p; flt_loc = loc; flt_mask = m;
        @(negedge clk);
        flt_we = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R5", "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // mirrored mode
        do_reset(1'b0);
        access(1, 0, 11'd3, 16'h1234, 0, "R6");
        access(0, 1, 11'd3, 0, 16'h1234, "R6");
        access(1, 0, 11'd1027, 16'hBEEF, 0, "R8");
        access(0, 1, 11'd3, 0, 16'hBEEF, "R8");
        access(1, 1, 11'd5, 16'h5A5A, 0, "R10");
        access(0, 1, 11'd5, 0, 16'h5A5A, "R10");
        inject(0, 10'd10, 16'h00FF);
        access(1, 0, 11'd10, 16'hA5A5, 0, "R6");
        access(0, 1, 11'd10, 0, 16'hA5A5, "R6");
        inject(1, 10'd11, 16'hF000);
        access(1, 0, 11'd11, 16'hFFFF, 0, "R6");
        access(0, 1, 11'd11, 0, 16'hFFFF, "R6");
        // strobe while busy is ignored
        access(1, 0, 11'd12, 16'h0C0C, 0, "R4");
        while (cpu_busy) @(negedge clk);
        begin
            sb_item_t it;
            it.is_rd = 1; it.exp = 16'h0C0C; it.req = "R4";
            sb_q.push_back(it);
            cpu_rd = 1; cpu_addr = 11'd12;
            @(negedge clk);
            cpu_rd = 0;
            cpu_wr = 1; cpu_addr = 11'd12; cpu_wdata = 16'hDEAD;
            @(negedge clk);
            cpu_wr = 0;
            while (cpu_busy) @(negedge clk);
        end
        repeat (2) @(negedge clk);
        chk(sb_q.size() == 0, "R4", "no extra access", sb_q.size(), 0);
        access(0, 1, 11'd12, 0, 16'h0C0C, "R4");
        // clear defect, let regeneration rewrite both planes
        inject(0, 10'd10, 16'h0000);
        repeat (1100 * M) @(negedge clk);
        chk(wrap_mir, "R3", "mirrored wrap 1023->0", wrap_mir, 1);

        // split mode, memory contents retained across reset
        do_reset(1'b1);
        access(0, 1, 11'd10, 0, 16'hA5A5, "R6");
        access(1, 0, 11'd20, 16'h1111, 0, "R7");
        access(1, 0, 11'd1044, 16'h2222, 0, "R7");
        access(0, 1, 11'd20, 0, 16'h1111, "R7");
        access(0, 1, 11'd1044, 0, 16'h2222, "R7");
        inject(1, 10'd30, 16'h0F0F);
        access(1, 0, 11'd1054, 16'hFFFF, 0, "R7");
        access(1, 0, 11'd30, 16'h1234, 0, "R7");
        access(0, 1, 11'd1054, 0, 16'hF0F0, "R7");
        access(0, 1, 11'd30, 0, 16'h1234, "R7");
        repeat (2100 * M) @(negedge clk);
        chk(cross_ext, "R3", "split 1023->1024", cross_ext, 1);
        chk(wrap_ext, "R3", "split wrap 2047->0", wrap_ext, 1);
        chk(sb_q.size() == 0, "R5", "scoreboard drained", sb_q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule